// File: doc/BRIEF.md
# Seventeen-Input Interrupt Router with Critical Priority Encoder

The block gathers seventeen interrupt requests into two interrupt lines for a processor core. Seven requests arrive from package pins and pass through a two-stage synchronizer. Ten come from on-chip peripherals that already run on the block's clock. Each request is first made active-high by its own polarity bit. A per-source trigger bit then picks one of two behaviours. In edge mode an inactive-to-active transition is caught in a sticky flag. In level mode the status follows the line itself.

Each source also has an enable bit and a routing bit. Together they send an enabled, pending request either to the critical line or to the normal line. For the critical line the block also reports which source should be serviced first. The choice comes from a table of priority slots, each holding a source number. The lowest-numbered slot that names a live critical source wins. Software uses a single-cycle register write port and a combinational read port to program the block, inspect it, and acknowledge edge-captured requests by writing ones.

Top module: `irq_hub`

## Requirements
- R1: After reset, reading the registers gives status 0, enable 0, routing 0, polarity 0x1FFFF, trigger 0, and slot k holding k. Both interrupt lines are low and `crit_id` reads 31.
- R2: Register addresses are 0 status, 1 enable, 2 routing, 3 polarity, 4 trigger, and 8+k for slot k (k = 0..16). Source bit n is `ext_irq[n]` for n < 7 and `int_irq[n-7]` otherwise.
- R3: In level mode (trigger bit 0), a source's status bit equals its polarity-adjusted input. External inputs reach status after two clock edges.
- R4: Polarity bit 1 makes a source active high and polarity bit 0 makes it active low, in both trigger modes.
- R5: In edge mode (trigger bit 1), an inactive-to-active transition lasting at least one clock cycle sets the status bit. The bit stays set after the input returns to inactive.
- R6: Writing a 1 to a bit of the status register clears an edge-captured status bit. Writing 0 leaves it unchanged.
- R7: Writing 1 to the status bit of a level-mode source whose input is still active has no effect: the bit still reads 1.
- R8: A source whose enable bit is 0 keeps its status bit but drives neither interrupt line.
- R9: An enabled source with a set status bit drives `crit_irq` when its routing bit is 1 and `noncrit_irq` when its routing bit is 0.
- R10: `crit_id` gives the source named by the lowest slot whose source is enabled, pending and routed critical. It gives 31 when no slot qualifies. A slot value of 17 or more never matches.
- R11: The enable, routing, polarity and trigger registers read back bits 16:0 of the value written, and the upper bits read 0. Slots read back bits 4:0 of the value written. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ext_irq | input | 7 | Asynchronous interrupt requests from pins |
| int_irq | input | 10 | Synchronous interrupt requests from on-chip peripherals |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| addr | input | 5 | Register address for both read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| crit_irq | output | 1 | Critical interrupt line to the core |
| noncrit_irq | output | 1 | Normal interrupt line to the core |
| crit_id | output | 5 | Highest-priority live critical source, 31 when none |

## Verification
The bench sweeps every source through both polarities, both trigger modes and both routings. A design with a lane swapped or an inverted polarity would show the wrong status bit or raise the wrong line. It drives a one-cycle pulse on each source in edge mode and then acknowledges it with partial and zero writes. A design that does not capture short pulses, that clears bits it was not told to clear, or that lets a level-mode source be cleared while still active would fail these checks. The priority check walks every pair of critical sources against a permuted slot table. The table includes a disabled source and a slot holding an out-of-range index. A reversed search order, a missing enable qualifier or a range check that lets index 31 alias a real source would each report the wrong `crit_id`.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  // Default shape of the block
  localparam int unsigned DEF_NUM_EXT = 7;
  localparam int unsigned DEF_NUM_INT = 10;
  localparam int unsigned DEF_ID_W    = 5;
  localparam int unsigned DEF_ADDR_W  = 5;
  localparam int unsigned DEF_DATA_W  = 32;

  // Register addresses
  localparam int unsigned REG_STAT  = 0;
  localparam int unsigned REG_EN    = 1;
  localparam int unsigned REG_CRIT  = 2;
  localparam int unsigned REG_POL   = 3;
  localparam int unsigned REG_TRIG  = 4;
  localparam int unsigned SLOT_BASE = 8;

  typedef enum logic [0:0] {
    TRIG_LEVEL = 1'b0,
    TRIG_EDGE  = 1'b1
  } trig_mode_e;
endpackage

// File: rtl/irq_hub_sync.sv
module irq_hub_sync #(
  parameter int unsigned W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  // Two flops per lane, each lane built separately
  for (genvar i = 0; i < int'(W); i++) begin : g_lane
    logic meta_q, stable_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q   <= 1'b0;
        stable_q <= 1'b0;
      end else begin
        meta_q   <= async_in[i];
        stable_q <= meta_q;
      end
    end
    assign sync_out[i] = stable_q;
  end
endmodule

// File: rtl/irq_hub_src.sv
module irq_hub_src #(
  parameter int unsigned N = 17
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  input  logic [N-1:0] pol,
  input  logic [N-1:0] trig,
  input  logic [N-1:0] clr,
  output logic [N-1:0] status,
  output logic [N-1:0] edge_q
);
  import irq_hub_pkg::*;

  for (genvar i = 0; i < int'(N); i++) begin : g_src
    logic active, prev_q, prev_d, flag_q, flag_d;

    // Active-high view of the request
    assign active = ~(raw[i] ^ pol[i]);

    always_comb begin
      prev_d = active;
      flag_d = flag_q;
      if (clr[i])
        flag_d = 1'b0;
      if (active && !prev_q)
        flag_d = 1'b1;          // a fresh edge beats a same-cycle clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q <= 1'b0;
        flag_q <= 1'b0;
      end else begin
        prev_q <= prev_d;
        flag_q <= flag_d;
      end
    end

    assign status[i] = (trig_mode_e'(trig[i]) == TRIG_EDGE) ? flag_q : active;
    assign edge_q[i] = flag_q;
  end
endmodule

// File: rtl/irq_hub_regs.sv
module irq_hub_regs #(
  parameter int unsigned N      = 17,
  parameter int unsigned ID_W   = 5,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]         wdata,
  input  logic [N-1:0]              status,
  output logic [DATA_W-1:0]         rdata,
  output logic [N-1:0]              en_q,
  output logic [N-1:0]              crit_q,
  output logic [N-1:0]              pol_q,
  output logic [N-1:0]              trig_q,
  output logic [N-1:0][ID_W-1:0]    slot_q,
  output logic [N-1:0]              clr
);
  import irq_hub_pkg::*;

  logic unused_wdata_hi;
  assign unused_wdata_hi = ^wdata[DATA_W-1:N];

  logic en_we, crit_we, pol_we, trig_we, stat_we;
  logic [N-1:0] slot_we;
  logic [N-1:0] en_d, crit_d, pol_d, trig_d;
  logic [N-1:0][ID_W-1:0] slot_d;

  // Write decode
  always_comb begin
    stat_we = wr_en && (addr == ADDR_W'(REG_STAT));
    en_we   = wr_en && (addr == ADDR_W'(REG_EN));
    crit_we = wr_en && (addr == ADDR_W'(REG_CRIT));
    pol_we  = wr_en && (addr == ADDR_W'(REG_POL));
    trig_we = wr_en && (addr == ADDR_W'(REG_TRIG));
    for (int k = 0; k < int'(N); k++)
      slot_we[k] = wr_en && (addr == ADDR_W'(SLOT_BASE + k));
  end

  assign clr = stat_we ? wdata[N-1:0] : '0;

  // Next state
  always_comb begin
    en_d   = en_we   ? wdata[N-1:0] : en_q;
    crit_d = crit_we ? wdata[N-1:0] : crit_q;
    pol_d  = pol_we  ? wdata[N-1:0] : pol_q;
    trig_d = trig_we ? wdata[N-1:0] : trig_q;
    for (int k = 0; k < int'(N); k++)
      slot_d[k] = slot_we[k] ? wdata[ID_W-1:0] : slot_q[k];
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      crit_q <= '0;
      pol_q  <= '1;
      trig_q <= '0;
    end else begin
      if (en_we)   en_q   <= en_d;
      if (crit_we) crit_q <= crit_d;
      if (pol_we)  pol_q  <= pol_d;
      if (trig_we) trig_q <= trig_d;
    end
  end

  for (genvar k = 0; k < int'(N); k++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot_q[k] <= ID_W'(k);
      else if (slot_we[k])
        slot_q[k] <= slot_d[k];
    end
  end

  // Read mux
  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_W'(REG_STAT): rdata[N-1:0] = status;
      ADDR_W'(REG_EN):   rdata[N-1:0] = en_q;
      ADDR_W'(REG_CRIT): rdata[N-1:0] = crit_q;
      ADDR_W'(REG_POL):  rdata[N-1:0] = pol_q;
      ADDR_W'(REG_TRIG): rdata[N-1:0] = trig_q;
      default: begin
        for (int k = 0; k < int'(N); k++)
          if (addr == ADDR_W'(SLOT_BASE + k))
            rdata[ID_W-1:0] = slot_q[k];
      end
    endcase
  end
endmodule

// File: rtl/irq_hub_prio.sv
module irq_hub_prio #(
  parameter int unsigned N    = 17,
  parameter int unsigned ID_W = 5
) (
  input  logic [N-1:0]           req,
  input  logic [N-1:0][ID_W-1:0] slot,
  output logic [ID_W-1:0]        id
);
  localparam int unsigned SPAN = 1 << ID_W;

  logic [SPAN-1:0] req_x;
  assign req_x = {{(SPAN-N){1'b0}}, req};

  // Scan from the last slot down so that the lowest qualifying slot wins
  always_comb begin
    id = '1;
    for (int k = int'(N) - 1; k >= 0; k--)
      if ((slot[k] < ID_W'(N)) && req_x[slot[k]])
        id = slot[k];
  end
endmodule

// File: rtl/irq_hub.sv
module irq_hub #(
  parameter int unsigned NUM_EXT = irq_hub_pkg::DEF_NUM_EXT,
  parameter int unsigned NUM_INT = irq_hub_pkg::DEF_NUM_INT,
  parameter int unsigned ID_W    = irq_hub_pkg::DEF_ID_W,
  parameter int unsigned ADDR_W  = irq_hub_pkg::DEF_ADDR_W,
  parameter int unsigned DATA_W  = irq_hub_pkg::DEF_DATA_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EXT-1:0] ext_irq,
  input  logic [NUM_INT-1:0] int_irq,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  output logic               crit_irq,
  output logic               noncrit_irq,
  output logic [ID_W-1:0]    crit_id
);
  localparam int unsigned NUM_SRC = NUM_EXT + NUM_INT;

  // Reset: asserted at once, released on a clock edge
  logic rst_meta_q, rst_n_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_n_q    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_q    <= rst_meta_q;
    end
  end

  logic [NUM_EXT-1:0] ext_sync;
  logic [NUM_SRC-1:0] raw, status, edge_q, clr;
  logic [NUM_SRC-1:0] en_q, crit_q, pol_q, trig_q, pending;
  logic [NUM_SRC-1:0][ID_W-1:0] slot_q;

  irq_hub_sync #(.W(NUM_EXT)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n_q),
    .async_in (ext_irq),
    .sync_out (ext_sync)
  );

  assign raw = {int_irq, ext_sync};

  irq_hub_src #(.N(NUM_SRC)) u_src (
    .clk    (clk),
    .rst_n  (rst_n_q),
    .raw    (raw),
    .pol    (pol_q),
    .trig   (trig_q),
    .clr    (clr),
    .status (status),
    .edge_q (edge_q)
  );

  irq_hub_regs #(
    .N(NUM_SRC), .ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_n_q),
    .wr_en  (wr_en),
    .addr   (addr),
    .wdata  (wdata),
    .status (status),
    .rdata  (rdata),
    .en_q   (en_q),
    .crit_q (crit_q),
    .pol_q  (pol_q),
    .trig_q (trig_q),
    .slot_q (slot_q),
    .clr    (clr)
  );

  assign pending     = status & en_q;
  assign crit_irq    = |(pending & crit_q);
  assign noncrit_irq = |(pending & ~crit_q);

  irq_hub_prio #(.N(NUM_SRC), .ID_W(ID_W)) u_prio (
    .req  (pending & crit_q),
    .slot (slot_q),
    .id   (crit_id)
  );
endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk #(
  parameter int unsigned N      = 17,
  parameter int unsigned ID_W   = 5,
  parameter int unsigned ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n_q,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [N-1:0]      status,
  input logic [N-1:0]      en_q,
  input logic [N-1:0]      crit_q,
  input logic [N-1:0]      edge_q,
  input logic              crit_irq,
  input logic              noncrit_irq,
  input logic [ID_W-1:0]   crit_id
);
  localparam int unsigned SPAN = 1 << ID_W;

  logic [SPAN-1:0] live_x;
  assign live_x = {{(SPAN-N){1'b0}}, status & en_q & crit_q};

  logic stat_write;
  assign stat_write = wr_en && (addr == ADDR_W'(irq_hub_pkg::REG_STAT));

  // R8: nothing enabled means both lines quiet
  p_masked_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n_q)
    (en_q == '0) |-> (!crit_irq && !noncrit_irq));

  // R10: a reported source implies the critical line is up
  p_id_needs_line_r10: assert property (@(posedge clk) disable iff (!rst_n_q)
    (crit_id != '1) |-> crit_irq);

  // R10: a reported source is enabled, pending and critical
  p_id_is_live_r10: assert property (@(posedge clk) disable iff (!rst_n_q)
    (crit_id != '1) |-> live_x[crit_id]);

  // R10: reported code is a real source or the idle code
  p_id_in_range_r10: assert property (@(posedge clk) disable iff (!rst_n_q)
    (crit_id == '1) || (crit_id < ID_W'(N)));

  // R5: a captured edge never drops without a status write
  p_edge_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n_q)
    !stat_write |=> ((edge_q & $past(edge_q)) == $past(edge_q)));
endmodule

bind irq_hub irq_hub_chk #(.N(NUM_SRC), .ID_W(ID_W), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n_q     (rst_n_q),
  .wr_en       (wr_en),
  .addr        (addr),
  .status      (status),
  .en_q        (en_q),
  .crit_q      (crit_q),
  .edge_q      (edge_q),
  .crit_irq    (crit_irq),
  .noncrit_irq (noncrit_irq),
  .crit_id     (crit_id)
);

// File: tb/test_irq_hub.sv
module test_irq_hub;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 17;
  localparam logic [16:0] ALL = 17'h1FFFF;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [16:0] drv;
  logic        wr_en;
  logic [4:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        crit_irq, noncrit_irq;
  logic [4:0]  crit_id;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int tb_slot [NS];
  logic [16:0] m_en, m_crit;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_hub i_irq_hub (
    .clk(clk), .rst_n(rst_n),
    .ext_irq(drv[6:0]), .int_irq(drv[16:7]),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .crit_irq(crit_irq), .noncrit_irq(noncrit_irq), .crit_id(crit_id)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = 5'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    addr = 5'(a);
    #1;
    d = rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
    #1;
  endtask

  function automatic int exp_id(input logic [16:0] live);
    for (int k = 0; k < NS; k++)
      if (tb_slot[k] < NS && live[tb_slot[k]]) return tb_slot[k];
    return 31;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; drv = '0; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();

    // R1 reset state
    rd(0, d); check("R1", "status", d, 0);
    rd(1, d); check("R1", "enable", d, 0);
    rd(2, d); check("R1", "routing", d, 0);
    rd(3, d); check("R1", "polarity", d, 32'h1FFFF);
    rd(4, d); check("R1", "trigger", d, 0);
    for (int k = 0; k < NS; k++) begin
      rd(8 + k, d); check("R1", "slot", d, k);
    end
    check("R1", "crit_irq", crit_irq, 0);
    check("R1", "noncrit_irq", noncrit_irq, 0);
    check("R1", "crit_id", crit_id, 31);

    // R11 readback masking and unused addresses
    for (int a = 1; a <= 4; a++) begin
      wr(a, 32'hDEAD_5A5A + a);
      rd(a, d); check("R11", "reg readback", d, (32'hDEAD_5A5A + a) & 32'h1FFFF);
    end
    wr(8 + 3, 32'hFFFF_FFE9);
    rd(8 + 3, d); check("R11", "slot readback", d, 32'h09);
    rd(5, d);  check("R11", "unused addr 5", d, 0);
    rd(31, d); check("R11", "unused addr 31", d, 0);
    wr(8 + 3, 3); wr(4, 0); wr(3, ALL); wr(2, 0); wr(1, 0);
    for (int k = 0; k < NS; k++) tb_slot[k] = k;

    // R2 R3 R4 R9 R10 level sweep, every source, both polarities and routes
    wr(1, ALL);
    for (int p = 0; p < 2; p++) begin
      logic [16:0] idle;
      idle = p ? 17'h0 : ALL;
      wr(3, p ? ALL : 32'h0);
      drv = idle;
      for (int i = 0; i < NS; i++) begin
        for (int r = 0; r < 2; r++) begin
          wr(2, r ? (32'h1 << i) : 32'h0);
          drv = idle ^ (17'h1 << i);
          settle();
          rd(0, d); check("R3 R4", "level status", d, 32'h1 << i);
          check("R9", "crit line", crit_irq, r);
          check("R9", "normal line", noncrit_irq, !r);
          check("R10", "single crit id", crit_id, r ? i : 31);
          drv = idle;
          settle();
          rd(0, d); check("R3", "status after release", d, 0);
        end
      end
    end

    // R7 level status ignores clear while active; R8 enable masking
    wr(3, ALL); wr(2, 0); drv = 17'h1 << 9;
    settle();
    wr(0, ALL);
    rd(0, d); check("R7", "level w1c ignored", d, 32'h1 << 9);
    wr(1, ALL & ~(17'h1 << 9));
    rd(0, d); check("R8", "status kept when disabled", d, 32'h1 << 9);
    check("R8", "normal line masked", noncrit_irq, 0);
    wr(2, ALL);
    check("R8", "crit line masked", crit_irq, 0);
    check("R8", "crit id masked", crit_id, 31);
    drv = '0; wr(1, ALL); wr(2, 0);

    // R5 R6 edge sweep, both polarities, one-cycle pulses
    for (int p = 0; p < 2; p++) begin
      logic [16:0] idle;
      idle = p ? 17'h0 : ALL;
      wr(4, 0); wr(3, p ? ALL : 32'h0);
      drv = idle;
      settle();
      wr(4, ALL); wr(0, ALL);
      for (int i = 0; i < NS; i++) begin
        @(negedge clk); drv = idle ^ (17'h1 << i);
        @(negedge clk); drv = idle;
        settle();
        rd(0, d); check("R5", "edge captured", d, 32'h1 << i);
        check("R5", "edge drives line", noncrit_irq, 1);
        wr(0, 0);
        rd(0, d); check("R6", "zero write keeps", d, 32'h1 << i);
        wr(0, ALL & ~(17'h1 << i));
        rd(0, d); check("R6", "other bits write keeps", d, 32'h1 << i);
        wr(0, 32'h1 << i);
        rd(0, d); check("R6", "one write clears", d, 0);
        check("R6", "line drops", noncrit_irq, 0);
      end
    end

    // R10 priority over permuted slots, a disabled source and a dead slot
    wr(4, 0); wr(3, ALL); drv = '0;
    settle();
    for (int k = 0; k < NS; k++) begin
      tb_slot[k] = (k * 5 + 3) % NS;
      if (k == 4) tb_slot[k] = 31;
      wr(8 + k, tb_slot[k]);
    end
    m_en = ALL & ~17'h4;
    m_crit = ALL;
    wr(1, m_en); wr(2, m_crit);
    for (int i = 0; i < NS; i++) begin
      for (int j = i; j < NS; j++) begin
        drv = (17'h1 << i) | (17'h1 << j);
        settle();
        check("R10", "pair crit id", crit_id, exp_id(drv & m_en & m_crit));
      end
    end
    drv = 17'h1 << 6;
    settle();
    check("R10", "unreachable source line", crit_irq, 1);
    check("R10", "unreachable source id", crit_id, 31);
    drv = '0;
    settle();
    check("R10", "idle id", crit_id, 31);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule